// File: doc/BRIEF.md
# Viterbi Survivor History and Traceback Unit

This block keeps the survivor history of a Viterbi decoder. Each timeslot it takes one decision bit per trellis state and the state that won globally in that slot, and stores both in a circular buffer. A second record per slot, the good path, holds the state that the decoder currently believes lies on the surviving path.

When the new global winner follows on from the previous winner, the good path just grows by one slot. When it does not, a single traceback engine walks backwards from the new winner. Each step derives the predecessor state from the stored decision bits and writes it over the good-path entry of the older slot. The walk ends as soon as a derived predecessor equals the state already recorded, or when it reaches its depth limit. While the engine walks, the input side stalls.

Decoded bits leave with a fixed slot latency. Once a slot is DEPTH-1 slots older than the newest one, the least significant bit of its good-path state is released as a one-cycle valid strobe.

Top module: `vtb_history_unit`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0.
- R2: A slot is accepted on a clock edge where in_valid and in_ready are both 1. When its winner w and the previous slot's winner p satisfy (w >> 1) == (p mod 2^(SW-1)), no traceback starts and in_ready stays 1 on the next cycle.
- R3: When an accepted slot (not the first) breaks that continuity, a traceback starts from its winner. Each step takes one cycle and forms the parent ((s >> 1) | (d << (SW-1))), where d is bit s of the decision vector of the slot holding s. A parent that differs from the good-path entry of the slot before is written over that entry.
- R4: The traceback stops on the first step whose parent equals the stored good-path entry of the slot before. That step still costs one busy cycle, and it writes nothing.
- R5: A traceback started by slot number t (counting from 0) takes at most min(t, DEPTH-2) steps. Good-path entries more than DEPTH-2 slots older than t are never changed.
- R6: in_ready is 0 for exactly as many cycles as the traceback has steps. A slot offered in that time is not taken and produces no output strobe.
- R7: On the cycle after slot t is accepted with t >= DEPTH-1, out_valid is 1 and out_bit is the LSB of the good-path state of slot t-DEPTH+1. After slots t < DEPTH-1, and in every cycle with no acceptance before it, out_valid is 0.
- R8: The first slot after reset never starts a traceback.
- R9: The buffer wraps around, and the behaviour above stays correct for runs many times longer than DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A new timeslot is offered |
| in_ready | output | 1 | The unit can take a timeslot this cycle |
| in_winner | input | SW | Global winning state of the timeslot |
| in_dec | input | 2^SW | Decision bit per state; bit s belongs to state s |
| out_valid | output | 1 | One-cycle strobe: a decoded bit is present |
| out_bit | output | 1 | Decoded bit |

## Verification
The bench builds the unit with SW=3 and DEPTH=8. Eight states keep the continuity and parent arithmetic easy to restate, and a depth of eight lets a single slot reach the six-step depth limit. A few dozen slots are enough to wrap the circular buffer many times. Together these bring early rejoins, limit-bounded walks, stalls with a slot held on the input, and the release of rewritten history all within a short run.

// File: rtl/vtb_pkg.sv
package vtb_pkg;

  typedef enum logic {
    TB_IDLE = 1'b0,
    TB_WALK = 1'b1
  } tb_state_e;

endpackage

// File: rtl/vtb_history_store.sv
module vtb_history_store #(
  parameter int SW    = 6,
  parameter int DEPTH = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     slot_we,
  input  logic [$clog2(DEPTH)-1:0] slot_idx,
  input  logic [SW-1:0]            slot_winner,
  input  logic [(1<<SW)-1:0]       slot_dec,
  input  logic                     fix_we,
  input  logic [$clog2(DEPTH)-1:0] fix_idx,
  input  logic [SW-1:0]            fix_state,
  input  logic [$clog2(DEPTH)-1:0] walk_idx,
  output logic [(1<<SW)-1:0]       walk_dec,
  input  logic [$clog2(DEPTH)-1:0] look_idx,
  output logic [SW-1:0]            look_state,
  input  logic [$clog2(DEPTH)-1:0] rel_idx,
  output logic [SW-1:0]            rel_state
);
  localparam int NS = 1 << SW;

  logic [NS-1:0] dec_mem  [DEPTH];
  logic [SW-1:0] path_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (slot_we) begin
      dec_mem[slot_idx]  <= slot_dec;
      path_mem[slot_idx] <= slot_winner;
    end else if (fix_we) begin
      path_mem[fix_idx] <= fix_state;
    end
  end

  assign walk_dec   = dec_mem[walk_idx];
  assign look_state = path_mem[look_idx];
  assign rel_state  = path_mem[rel_idx];

  // R6: slot writes and traceback rewrites never share a cycle
  p_one_writer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(slot_we && fix_we));

  // R3: a rewrite always changes the stored good-path entry
  p_fix_changes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fix_we |-> (fix_state != path_mem[fix_idx]));

endmodule

// File: rtl/vtb_tracer.sv
module vtb_tracer
  import vtb_pkg::*;
#(
  parameter int SW    = 6,
  parameter int DEPTH = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     slot_take,
  input  logic [SW-1:0]            slot_winner,
  input  logic [$clog2(DEPTH)-1:0] wp,
  input  logic [$clog2(DEPTH)-1:0] seen,
  input  logic [(1<<SW)-1:0]       walk_dec,
  input  logic [SW-1:0]            look_state,
  output logic                     busy,
  output logic [$clog2(DEPTH)-1:0] walk_idx,
  output logic [$clog2(DEPTH)-1:0] look_idx,
  output logic                     fix_we,
  output logic [SW-1:0]            fix_state
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [IDX_W-1:0] LIM = IDX_W'(DEPTH - 2);

  function automatic logic [SW-1:0] parent_of(input logic [SW-1:0] s, input logic d);
    return {d, s[SW-1:1]};
  endfunction

  function automatic logic is_child(input logic [SW-1:0] s, input logic [SW-1:0] p);
    return s[SW-1:1] == p[SW-2:0];
  endfunction

  function automatic logic [IDX_W-1:0] step_back(input logic [IDX_W-1:0] i);
    return (i == '0) ? IDX_W'(DEPTH - 1) : i - 1'b1;
  endfunction

  tb_state_e        st;
  logic [SW-1:0]    cur;
  logic [IDX_W-1:0] steps_left;
  logic [SW-1:0]    last_winner;

  // named internal events
  logic          walk_bit;
  logic [SW-1:0] walk_parent;
  logic          walk_match;
  logic          walk_done;
  logic          jump_seen;
  logic          first_slot;
  logic [IDX_W-1:0] start_steps;

  assign walk_bit    = walk_dec[cur];
  assign walk_parent = parent_of(cur, walk_bit);
  assign walk_match  = (walk_parent == look_state);
  assign walk_done   = walk_match || (steps_left == IDX_W'(1));
  assign first_slot  = (seen == '0);
  assign jump_seen   = slot_take && !first_slot && !is_child(slot_winner, last_winner);
  assign start_steps = (seen > LIM) ? LIM : seen;

  assign busy      = (st == TB_WALK);
  assign look_idx  = step_back(walk_idx);
  assign fix_we    = busy && !walk_match;
  assign fix_state = walk_parent;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= TB_IDLE;
      cur         <= '0;
      walk_idx    <= '0;
      steps_left  <= '0;
      last_winner <= '0;
    end else begin
      if (slot_take) begin
        last_winner <= slot_winner;
      end
      unique case (st)
        TB_IDLE: begin
          if (jump_seen) begin
            st         <= TB_WALK;
            cur        <= slot_winner;
            walk_idx   <= wp;
            steps_left <= start_steps;
          end
        end
        TB_WALK: begin
          if (walk_done) begin
            st <= TB_IDLE;
          end else begin
            cur        <= walk_parent;
            walk_idx   <= look_idx;
            steps_left <= steps_left - 1'b1;
          end
        end
        default: st <= TB_IDLE;
      endcase
    end
  end

  // R6: a slot is only taken while no traceback runs
  p_take_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    slot_take |-> (st == TB_IDLE));

  // R8: the first slot never starts a walk
  p_first_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_take && first_slot) |=> (st == TB_IDLE));

  // R2: a winner that extends the path leaves the engine idle
  p_extend_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_take && is_child(slot_winner, last_winner)) |=> (st == TB_IDLE));

  // R5: the remaining step budget stays within the depth limit
  p_depth_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == TB_WALK) |-> (steps_left != '0 && steps_left <= LIM));

  // R4: a rejoin ends the walk on the next cycle
  p_rejoin_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == TB_WALK && walk_match) |=> (st == TB_IDLE));

endmodule

// File: rtl/vtb_release.sv
module vtb_release #(
  parameter int DEPTH = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     slot_take,
  input  logic                     rel_lsb,
  output logic [$clog2(DEPTH)-1:0] wp,
  output logic [$clog2(DEPTH)-1:0] seen,
  output logic [$clog2(DEPTH)-1:0] rel_idx,
  output logic                     out_valid,
  output logic                     out_bit
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(DEPTH - 1);

  logic history_full;

  assign history_full = (seen == TOP);
  // the slot DEPTH-1 behind wp sits one position ahead of it in the ring
  assign rel_idx = (wp == TOP) ? '0 : wp + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp        <= '0;
      seen      <= '0;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      out_valid <= slot_take && history_full;
      if (slot_take) begin
        wp      <= (wp == TOP) ? '0 : wp + 1'b1;
        out_bit <= rel_lsb;
        if (!history_full) begin
          seen <= seen + 1'b1;
        end
      end
    end
  end

  // R7: a decoded bit only follows an accepted slot
  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(slot_take));

  // R7: no strobe before the history has filled
  p_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_take && !history_full) |=> !out_valid);

endmodule

// File: rtl/vtb_history_unit.sv
module vtb_history_unit #(
  parameter int SW    = 6,
  parameter int DEPTH = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SW-1:0]       in_winner,
  input  logic [(1<<SW)-1:0]  in_dec,
  output logic                out_valid,
  output logic                out_bit
);
  localparam int NS    = 1 << SW;
  localparam int IDX_W = $clog2(DEPTH);

  logic             slot_take;
  logic             busy;
  logic [IDX_W-1:0] wp;
  logic [IDX_W-1:0] seen;
  logic [IDX_W-1:0] rel_idx;
  logic [IDX_W-1:0] walk_idx;
  logic [IDX_W-1:0] look_idx;
  logic [NS-1:0]    walk_dec;
  logic [SW-1:0]    look_state;
  logic [SW-1:0]    rel_state;
  logic             fix_we;
  logic [SW-1:0]    fix_state;

  assign in_ready  = !busy;
  assign slot_take = in_valid && in_ready;

  vtb_history_store #(.SW(SW), .DEPTH(DEPTH)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .slot_we     (slot_take),
    .slot_idx    (wp),
    .slot_winner (in_winner),
    .slot_dec    (in_dec),
    .fix_we      (fix_we),
    .fix_idx     (look_idx),
    .fix_state   (fix_state),
    .walk_idx    (walk_idx),
    .walk_dec    (walk_dec),
    .look_idx    (look_idx),
    .look_state  (look_state),
    .rel_idx     (rel_idx),
    .rel_state   (rel_state)
  );

  vtb_tracer #(.SW(SW), .DEPTH(DEPTH)) u_tracer (
    .clk         (clk),
    .rst_n       (rst_n),
    .slot_take   (slot_take),
    .slot_winner (in_winner),
    .wp          (wp),
    .seen        (seen),
    .walk_dec    (walk_dec),
    .look_state  (look_state),
    .busy        (busy),
    .walk_idx    (walk_idx),
    .look_idx    (look_idx),
    .fix_we      (fix_we),
    .fix_state   (fix_state)
  );

  vtb_release #(.DEPTH(DEPTH)) u_release (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_take (slot_take),
    .rel_lsb   (rel_state[0]),
    .wp        (wp),
    .seen      (seen),
    .rel_idx   (rel_idx),
    .out_valid (out_valid),
    .out_bit   (out_bit)
  );

  // R1: the unit can take a slot while no walk is pending
  p_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !slot_take) |=> in_ready);

endmodule

// File: tb/vtb_history_unit_test.sv
`timescale 1ns/1ps
module vtb_history_unit_test;
  localparam int SW    = 3;
  localparam int DEPTH = 8;
  localparam int NS    = 1 << SW;
  localparam int HALF  = NS / 2;
  localparam int MAXS  = 512;

  // stimulus vectors: {winner[2:0], decisions[7:0]}
  localparam logic [10:0] STIM [16] = '{
    {3'd0, 8'h00}, {3'd1, 8'h5A}, {3'd2, 8'h3C}, {3'd5, 8'hA5},
    {3'd3, 8'hF0}, {3'd7, 8'h0F}, {3'd6, 8'h99}, {3'd4, 8'h66},
    {3'd6, 8'h81}, {3'd5, 8'h42}, {3'd0, 8'hFF}, {3'd1, 8'h00},
    {3'd7, 8'h18}, {3'd6, 8'h24}, {3'd2, 8'hC3}, {3'd4, 8'h7E}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [SW-1:0] in_winner = '0;
  logic [NS-1:0] in_dec = '0;
  logic          out_valid;
  logic          out_bit;

  always #2.5 clk = ~clk;

  vtb_history_unit #(.SW(SW), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_winner(in_winner), .in_dec(in_dec), .out_valid(out_valid), .out_bit(out_bit)
  );

  int n_chk = 0;
  int n_fail = 0;
  int t = 0;
  int n_out = 0;
  int gp [MAXS];
  int dm [MAXS];
  bit saw_limit = 0;
  bit saw_early = 0;
  bit saw_deep_one = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s slot=%0d actual=%0d expected=%0d", req, t, act, exp);
    end
  endtask

  // reference: record the slot and walk back as the requirements describe
  task automatic model_slot(input int w, input int d, output int steps, output bit jump);
    int lim, cur, k, par;
    steps = 0;
    jump  = 0;
    if (t > 0 && (w / 2) != (gp[t-1] % HALF)) begin
      jump = 1;
      lim  = (t < DEPTH - 2) ? t : DEPTH - 2;
      cur  = w;
      k    = t;
      gp[t] = w;
      dm[t] = d;
      for (int n = 0; n < lim; n++) begin
        par = cur / 2 + ((dm[k] >> cur) & 1) * HALF;
        steps++;
        if (gp[k-1] == par) begin
          if (steps < lim) saw_early = 1;
          break;
        end
        gp[k-1] = par;
        if (steps == DEPTH - 2) begin
          saw_limit = 1;
          if (par % 2 == 1) saw_deep_one = 1;
        end
        cur = par;
        k--;
      end
    end
    gp[t] = w;
    dm[t] = d;
  endtask

  task automatic send(input int w, input int d);
    int  steps, busy_cyc, exp_bit;
    bit  jump, exp_v;
    exp_v   = (t >= DEPTH - 1);
    exp_bit = exp_v ? (gp[t - DEPTH + 1] % 2) : 0;
    model_slot(w, d, steps, jump);
    in_valid  = 1'b1;
    in_winner = SW'(w);
    in_dec    = NS'(d);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == exp_v, "R7 strobe", int'(out_valid), int'(exp_v));
    if (out_valid) n_out++;
    if (exp_v) begin
      if (t >= DEPTH) chk(out_bit == exp_bit[0], "R9 wrapped release bit", int'(out_bit), exp_bit);
      else            chk(out_bit == exp_bit[0], "R7 release bit", int'(out_bit), exp_bit);
    end
    busy_cyc = 0;
    while (!in_ready && busy_cyc < 50) begin
      busy_cyc++;
      in_valid  = 1'b1;              // offer a different slot while stalled
      in_winner = ~SW'(w);
      in_dec    = ~NS'(d);
      @(negedge clk);
      chk(!out_valid, "R6 offered slot ignored", int'(out_valid), 0);
    end
    in_valid = 1'b0;
    if (t == 0)     chk(busy_cyc == 0, "R8 first slot", busy_cyc, 0);
    else if (!jump) chk(busy_cyc == 0, "R2 extend", busy_cyc, 0);
    else            chk(busy_cyc == steps, "R3 R4 R5 walk length", busy_cyc, steps);
    t++;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    int prev, w;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready in reset", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1 no strobe in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1 idle output", int'(out_valid), 0);

    // table-driven phase
    for (int i = 0; i < 16; i++) begin
      send(int'(STIM[i][10:8]), int'(STIM[i][7:0]));
    end

    // depth limit: long run of state 0, then jump to 7 with every parent 7
    for (int i = 0; i < 12; i++) send(0, 8'h80);
    send(7, 8'h80);
    for (int i = 0; i < 10; i++) send(7, 8'h80);
    chk(saw_limit, "R5 limit reached", int'(saw_limit), 1);
    chk(saw_deep_one, "R5 rewritten history released", int'(saw_deep_one), 1);

    // pseudo-random phase over many buffer wraps
    lf = 16'hACE1;
    prev = 7;
    for (int i = 0; i < 150; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf[0]) w = {prev[1:0], lf[1]};
      else       w = int'(lf[4:2]);
      send(w, int'(lf[12:5]));
      prev = w;
    end
    chk(saw_early, "R4 early rejoin seen", int'(saw_early), 1);
    chk(n_out == t - (DEPTH - 1), "R7 strobe count", n_out, t - (DEPTH - 1));

    // no input: output stays quiet
    repeat (4) @(negedge clk);
    chk(!out_valid && in_ready, "R7 quiet without input", int'(out_valid), 0);

    // reset again: the next slot is a first slot
    rst_n = 1'b0;
    @(negedge clk);
    chk(in_ready && !out_valid, "R1 second reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    t = 0;
    send(5, 8'h00);
    send(0, 8'h00);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule